// File: doc/BRIEF.md
# Multi-Lane Conversion Result Serializer

This block takes a finished conversion result from a converter core and shifts it out to a host over an SPI-style link. The host owns the serial clock and the chip select; the block samples both with its own system clock, which must run several times faster than the serial clock. A result is captured on a done strobe. It stays available for readout until the next convert-start rising edge begins a new conversion.

The number of data outputs in use is configurable: one, two or four lanes. More lanes cut the number of serial clock periods needed per frame. The lane setting is sampled when the frame starts. Bits leave most significant first. A result width that the lane count does not divide is padded at the end with zero bits. While chip select is high, the data pins are released to high impedance.

A sticky error output catches two frame-window violations. The first is a frame that opens before a fresh result exists. The second is a convert-start edge that arrives while a frame is still open. The flag clears only on reset.

Top module: `conv_serializer`

## Requirements
- R1: After reset the error flag is low, every output enable is low, and no result is held, so a frame opened before any done strobe is an error.
- R2: A done strobe captures result_i. Later changes on result_i do not alter the value shifted out until the next done strobe.
- R3: Lane mode 2'b00 (single) puts one bit per serial clock on sdo_o[0], most significant first. sdo_o[3:1] are driven low.
- R4: Lane mode 2'b01 (dual) puts two consecutive bits per serial clock on the lanes. The earlier bit goes on sdo_o[1] and the later on sdo_o[0]. sdo_o[3:2] are driven low.
- R5: Lane mode 2'b10 (quad) puts four consecutive bits per serial clock on the lanes, with the earliest on sdo_o[3].
- R6: Lane mode 2'b11 behaves exactly as single mode.
- R7: A frame takes ceil(W/N) serial clock periods for N active lanes. When W is not a multiple of N, the last group is filled with trailing zeros, and any shifting past the frame yields zeros.
- R8: The first group appears on the lanes one clock after chip select falls. Each falling serial clock edge advances one group. While chip select is high, all four lanes are high impedance and sdo_oe_o is zero.
- R9: The error flag sets when chip select falls and no result has been captured since reset or since the last convert-start rising edge.
- R10: The error flag sets when convert-start rises while a frame is open. A convert-start rising edge also withdraws the held result.
- R11: Once set, the error flag stays high until reset. It never sets during frames that respect the window.
- R12: The lane mode is captured when chip select falls. Changing lane_mode_i during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the link |
| rst_ni | input | 1 | Active-low asynchronous reset |
| result_i | input | W | Parallel conversion result |
| done_i | input | 1 | Conversion complete strobe, captures result_i |
| cnv_i | input | 1 | Convert-start; the rising edge opens a new conversion |
| cs_ni | input | 1 | Active-low chip select from the host |
| sck_i | input | 1 | Serial clock from the host |
| lane_mode_i | input | 2 | 00 single, 01 dual, 10 quad, 11 single |
| sdo_o | output | 4 | Serial data lanes, high impedance when idle |
| sdo_oe_o | output | 4 | Per-lane drive enable |
| err_o | output | 1 | Sticky frame-window error |

## Verification
Each lane mode, including the reserved code, runs against alternating, single-end-bit, all-zero, all-one and mixed words. These patterns expose a swapped lane, a reversed bit order or an off-by-one group boundary. A second instance with a 10-bit result repeats every frame, so the trailing-zero padding and the shorter group count in quad mode show up next to the unpadded 16-bit case. Separate runs open a frame with no result, raise convert-start inside a frame, and raise it between capture and readout; each isolates one cause of the error flag. A mid-frame lane-mode change checks that the captured mode holds.

// File: rtl/cser_pkg.sv
package cser_pkg;
  typedef enum logic [1:0] {
    LM_SINGLE = 2'b00,
    LM_DUAL   = 2'b01,
    LM_QUAD   = 2'b10,
    LM_RSVD   = 2'b11
  } lane_mode_e;

  localparam int unsigned MAX_LANES = 4;

  function automatic logic [2:0] lane_cnt(input logic [1:0] m);
    case (lane_mode_e'(m))
      LM_DUAL: return 3'd2;
      LM_QUAD: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/cser_capture.sv
module cser_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] result_i,
  input  logic         done_i,
  input  logic         cnv_rise_i,
  output logic [W-1:0] hold_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      valid_o <= 1'b0;
    end else if (done_i) begin
      hold_o  <= result_i;
      valid_o <= 1'b1;
    end else if (cnv_rise_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cser_shift.sv
module cser_shift #(
  parameter int unsigned W    = 16,
  parameter int unsigned PADW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [2:0]   step_i,
  input  logic [W-1:0] din_i,
  output logic [3:0]   top_o
);
  logic [PADW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= PADW'(din_i) << (PADW - W);
    else if (shift_i) sr_q <= sr_q << step_i;
  end

  assign top_o = sr_q[PADW-1 -: 4];
endmodule

// File: rtl/cser_lane_map.sv
module cser_lane_map #(
  parameter int unsigned LANES = 4
) (
  input  logic [3:0]       top_i,
  input  logic [2:0]       cnt_i,
  output logic [LANES-1:0] lanes_o
);
  // lane k carries top bit (4 - cnt + k); unused lanes low
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes_o[k] = (k < int'(cnt_i)) ? top_i[2'(4 - int'(cnt_i) + k)] : 1'b0;
  end
endmodule

// File: rtl/conv_serializer.sv
module conv_serializer
  import cser_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] result_i,
  input  logic         done_i,
  input  logic         cnv_i,
  input  logic         cs_ni,
  input  logic         sck_i,
  input  logic [1:0]   lane_mode_i,
  output logic [3:0]   sdo_o,
  output logic [3:0]   sdo_oe_o,
  output logic         err_o
);
  localparam int unsigned PADW = ((W + MAX_LANES - 1) / MAX_LANES) * MAX_LANES;

  logic         cs_q, sck_q, cnv_q, err_q;
  logic [1:0]   lane_q;
  logic         cs_fall, sck_fall, cnv_rise;
  logic [W-1:0] hold_q;
  logic         valid_q;
  logic [3:0]   top4, lanes;
  logic [2:0]   cnt;

  assign cs_fall  = cs_q & ~cs_ni;
  assign sck_fall = ~cs_q & ~cs_ni & sck_q & ~sck_i;
  assign cnv_rise = cnv_i & ~cnv_q;
  assign cnt      = lane_cnt(lane_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      cnv_q  <= 1'b0;
      lane_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      cs_q  <= cs_ni;
      sck_q <= sck_i;
      cnv_q <= cnv_i;
      if (cs_fall) lane_q <= lane_mode_i;
      if ((cs_fall && !valid_q) || (cnv_rise && !cs_q)) err_q <= 1'b1;
    end
  end

  cser_capture #(.W(W)) cap_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .result_i   (result_i),
    .done_i     (done_i),
    .cnv_rise_i (cnv_rise),
    .hold_o     (hold_q),
    .valid_o    (valid_q)
  );

  cser_shift #(.W(W), .PADW(PADW)) shf_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cs_fall),
    .shift_i (sck_fall),
    .step_i  (cnt),
    .din_i   (hold_q),
    .top_o   (top4)
  );

  cser_lane_map #(.LANES(MAX_LANES)) map_i (
    .top_i   (top4),
    .cnt_i   (cnt),
    .lanes_o (lanes)
  );

  for (genvar k = 0; k < 4; k++) begin : g_pin
    assign sdo_o[k] = cs_q ? 1'bz : lanes[k];
  end

  assign sdo_oe_o = {4{~cs_q}};
  assign err_o    = err_q;
endmodule

// File: rtl/cser_chk.sv
module cser_chk #(
  parameter int unsigned W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       cnv_i,
  input logic       done_i,
  input logic       err_o,
  input logic [3:0] sdo_oe_o,
  input logic       cs_q,
  input logic [1:0] lane_q,
  input logic [3:0] lanes,
  input logic       valid_q
);
  // R8
  idle_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (sdo_oe_o == 4'h0));
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R9
  early_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_ni) && !valid_q) |=> err_o);
  // R10
  cnv_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cnv_i) && !cs_q) |=> err_o);
  // R10
  cnv_withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cnv_i) && !done_i) |=> !valid_q);
  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> valid_q);
  // R3
  single_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && (lane_q == 2'b00 || lane_q == 2'b11)) |-> (lanes[3:1] == 3'b000));
  // R4
  dual_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && lane_q == 2'b01) |-> (lanes[3:2] == 2'b00));
endmodule

bind conv_serializer cser_chk #(.W(W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .cnv_i    (cnv_i),
  .done_i   (done_i),
  .err_o    (err_o),
  .sdo_oe_o (sdo_oe_o),
  .cs_q     (cs_q),
  .lane_q   (lane_q),
  .lanes    (lanes),
  .valid_q  (valid_q)
);

// File: tb/conv_serializer_tb_top.sv
module conv_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result = '0;
  logic        done = 1'b0, cnv = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [1:0]  mode = 2'b00;
  wire  [3:0]  sdo_a, sdo_b;
  logic [3:0]  oe_a, oe_b;
  logic        err_a, err_b;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  conv_serializer #(.W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result), .done_i(done), .cnv_i(cnv),
    .cs_ni(cs_n), .sck_i(sck), .lane_mode_i(mode), .sdo_o(sdo_a), .sdo_oe_o(oe_a),
    .err_o(err_a));

  conv_serializer #(.W(10)) pad_i (
    .clk_i(clk), .rst_ni(rst_n), .result_i(result[9:0]), .done_i(done), .cnv_i(cnv),
    .cs_ni(cs_n), .sck_i(sck), .lane_mode_i(mode), .sdo_o(sdo_b), .sdo_oe_o(oe_b),
    .err_o(err_b));

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expv(input logic [15:0] v, input int c, input int g);
    logic [3:0] r = '0;
    for (int k = 0; k < c; k++) begin
      int p = g * c + (c - 1 - k);
      r[k] = (p < 16) ? v[15 - p] : 1'b0;
    end
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; done = 0; cnv = 0; cs_n = 1; sck = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic capture(input logic [15:0] d);
    result = d; done = 1'b1; cyc();
    done = 1'b0; result = ~d; cyc();   // R2: later input changes must not matter
  endtask

  task automatic run_frame(input logic [15:0] d, input logic [1:0] m, input bit swap);
    int c = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    string req = swap ? "R12" : (m == 2'b11) ? "R6" : (c == 1) ? "R3" : (c == 2) ? "R4" : "R5";
    logic [15:0] vb = {d[9:0], 6'b0};
    capture(d);
    mode = m; cs_n = 1'b0; cyc();
    if (swap) mode = (m == 2'b10) ? 2'b00 : 2'b10;
    for (int g = 0; g < (16 + c - 1) / c; g++) begin
      if (g > 0) begin sck = 1'b1; cyc(); sck = 1'b0; cyc(); end
      chk(sdo_a === expv(d, c, g), {req, " R2 R8 main"}, {12'b0, sdo_a}, {12'b0, expv(d, c, g)});
      chk(sdo_b === expv(vb, c, g), {req, " R7 padded"}, {12'b0, sdo_b}, {12'b0, expv(vb, c, g)});
      chk(oe_a == 4'hf && oe_b == 4'hf, "R8 drive in frame", {8'b0, oe_a, oe_b}, 16'h00ff);
    end
    cs_n = 1'b1; cyc();
    chk(oe_a == 4'h0 && oe_b == 4'h0, "R8 release", {8'b0, oe_a, oe_b}, 16'h0);
    chk(err_a == 1'b0 && err_b == 1'b0, "R11 no error", {14'b0, err_a, err_b}, 16'h0);
    cyc();
  endtask

  initial begin
    logic [15:0] pats [6] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'h0000, 16'hFFFF, 16'h1234};
    do_reset();
    // R1
    chk(oe_a == 0 && oe_b == 0, "R1 reset enables", {8'b0, oe_a, oe_b}, 16'h0);
    chk(err_a == 0 && err_b == 0, "R1 reset error", {14'b0, err_a, err_b}, 16'h0);

    for (int i = 0; i < 6; i++)
      for (int m = 0; m < 4; m++)
        run_frame(pats[i], 2'(m), 1'b0);
    for (int b = 0; b < 16; b++) run_frame(16'(1) << b, 2'b10, 1'b0);
    run_frame(16'hC3A5, 2'b10, 1'b1);
    run_frame(16'h5A3C, 2'b00, 1'b1);

    // R1 R9: frame with nothing captured since reset
    do_reset();
    cs_n = 1'b0; cyc(); cyc();
    chk(err_a && err_b, "R1 R9 early frame", {14'b0, err_a, err_b}, 16'h3);
    cs_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc();
    chk(err_a && err_b, "R11 sticky", {14'b0, err_a, err_b}, 16'h3);

    // R10: convert-start inside frame
    do_reset();
    capture(16'h1111);
    cs_n = 1'b0; cyc();
    chk(!err_a && !err_b, "R10 before edge", {14'b0, err_a, err_b}, 16'h0);
    cnv = 1'b1; cyc(); cyc();
    chk(err_a && err_b, "R10 convert in frame", {14'b0, err_a, err_b}, 16'h3);
    cnv = 1'b0; cs_n = 1'b1; cyc();

    // R10: convert-start withdraws held result
    do_reset();
    capture(16'h2222);
    cnv = 1'b1; cyc(); cnv = 1'b0; cyc();
    chk(!err_a && !err_b, "R10 idle convert", {14'b0, err_a, err_b}, 16'h0);
    cs_n = 1'b0; cyc(); cyc();
    chk(err_a && err_b, "R10 withdrawn result", {14'b0, err_a, err_b}, 16'h3);
    cs_n = 1'b1; cyc();

    // R2: fresh capture after convert-start is readable
    do_reset();
    capture(16'h0F0F);
    cnv = 1'b1; cyc(); cnv = 1'b0; cyc();
    run_frame(16'h9C6B, 2'b01, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule